// File: doc/BRIEF.md
# DRAM Bank Sequencer with Core and External-Master Ports

This block decides which of its DRAM banks a transfer belongs to and then drives the row and column strobes, the transfer acknowledge (TA) and the address-bus enable through a four-byte read burst. A transfer comes from one of two places: the processor core or an external bus master. Each bank is set up through a simple load port. The setup holds a base address, an address mask, four per-access-type refuse bits, a page-mode select and a precharge length.

The rules depend on which side started the transfer. An external master cannot drive the top address bits. For its transfers the comparison treats those bits as zero, and it also treats bits 27:24 as zero when those pins are not routed to the outside. External transfers skip the access-type refuse bits. They always use burst-page timing, so RAS closes at the end of the burst. A core transfer to a fast-page bank leaves the row open instead. When no bank matches, no strobe moves and a one-cycle flag is raised.

Top module: `dram_xm_ctrl`

## Requirements
- R1: A bank matches when every address bit whose mask bit is 0 equals the same bit of its base. When more than one bank matches, the lowest-numbered bank is used.
- R2: For external transfers (`req_ext`=1), bits 31:28 are compared as zero. Bits 27:24 are also compared as zero when `hi_pins_ext`=0; when it is 1 they are compared as given.
- R3: `cfg_deny` bit n refuses core transfers of access type n (0 user code, 1 user data, 2 supervisor code, 3 supervisor data, taken from `req_type`). External transfers ignore all four bits.
- R4: A request that matches no bank moves no RAS, CAS or TA and does not drive the address bus. `no_hit` is high for exactly the one cycle after acceptance, and `req_ready` stays high.
- R5: A request is accepted on a clock edge while `req_ready` is high. This is followed by at least one wait cycle, then one row cycle, then four bytes. In the row cycle, RAS of the chosen bank is asserted and `mux_addr` holds address bits 19:10. Each byte `mux_addr` carries address bits 9:2 above a two-bit byte index that runs 0,1,2,3. RAS stays asserted throughout.
- R6: Each byte takes one setup cycle with CAS and TA low, then one strobe cycle with CAS and TA high. TA is never high on two cycles in a row.
- R7: In the cycle after the last strobe, CAS, TA and `addr_oe` all go low together while `ta_oe` is still high. `ta_oe` drops in the following cycle.
- R8: In burst-page mode, RAS goes low in that same end cycle and the bank's precharge counter starts at P = `cfg_pre`+1. RAS of that bank stays low for at least P+1 cycles.
- R9: A core transfer to a bank with `cfg_fast`=1 keeps that bank's RAS asserted after the burst while the block is idle. The next accepted matching request drops it for a close cycle, which starts that bank's precharge. External transfers to such a bank use burst-page mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the selected bank's setup |
| cfg_sel | input | BW | Bank to load |
| cfg_base | input | 32 | Base address |
| cfg_mask | input | 32 | Address mask, 1 = bit not compared |
| cfg_deny | input | 4 | Per-access-type refuse bits for core transfers |
| cfg_fast | input | 1 | Fast-page mode for core transfers |
| cfg_pre | input | 2 | Precharge length minus one |
| hi_pins_ext | input | 1 | Address bits 27:24 are driven by the external master |
| req_valid | input | 1 | Transfer request |
| req_ext | input | 1 | 1 = external master, 0 = core |
| req_type | input | 2 | Access type of a core transfer |
| req_addr | input | 32 | Transfer address |
| req_ready | output | 1 | Block can accept a request |
| ras_o | output | NB | Row strobe per bank, active high |
| cas_o | output | 1 | Column strobe, active high |
| ta_o | output | 1 | Transfer acknowledge, active high |
| ta_oe | output | 1 | TA is driven |
| addr_oe | output | 1 | Address bus is driven |
| mux_addr | output | MA_W | Multiplexed row/column address |
| no_hit | output | 1 | One-cycle flag for a request that matched no bank |

## Verification
The assertions check the pin rules on every cycle:
- TA never lasts two cycles.
- TA never comes without the bus driven and a single row open.
- At the end of a burst the strobes fall together, and TA is released one cycle later.
- A burst-page bank's RAS is low when its end cycle comes.
- A fast-page bank's RAS is held through its end cycle.
- RAS never rises while its bank is precharging.
- A no-hit cycle is quiet.

Only the bench scenarios can show the following:
- Which bank an address selects, including the external-master zeroing of the upper bits and the refuse-bit positions.
- The exact row and column values in each byte.
- That an open fast page survives idle cycles and is closed by the next request.
- The measured length of the precharge gap.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    localparam int AW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_WAIT,
        ST_ROW,
        ST_CSET,
        ST_CSTB,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] mask;
        logic [3:0]    deny;
        logic          fast;
        logic [1:0]    pre;
    } bank_cfg_t;

    // Address as seen by the comparator: an external master cannot drive
    // the top nibble, and bits 27:24 only when those pins are routed out.
    function automatic logic [AW-1:0] ext_view(input logic [AW-1:0] a,
                                               input logic ext,
                                               input logic hi_ok);
        logic [AW-1:0] r;
        r = a;
        if (ext) begin
            r[31:28] = 4'h0;
            if (!hi_ok) r[27:24] = 4'h0;
        end
        return r;
    endfunction

endpackage

// File: rtl/dxc_bank_regs.sv
module dxc_bank_regs import dxc_pkg::*; #(
    parameter int NB = 2,
    parameter int BW = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [BW-1:0]        cfg_sel,
    input  bank_cfg_t            cfg_in,
    input  logic [NB-1:0]        pre_start,
    input  logic [NB-1:0]        ras_i,
    output bank_cfg_t [NB-1:0]   cfg_q,
    output logic [NB-1:0]        pre_busy
);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic [2:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[b].base <= '1;
                    cfg_q[b].mask <= '0;
                    cfg_q[b].deny <= 4'hF;
                    cfg_q[b].fast <= 1'b0;
                    cfg_q[b].pre  <= 2'd0;
                end else if (cfg_wr && (cfg_sel == BW'(b))) begin
                    cfg_q[b] <= cfg_in;
                end
            end

            always_ff @(posedge clk) begin
                if (rst)               cnt <= '0;
                else if (pre_start[b]) cnt <= {1'b0, cfg_q[b].pre} + 3'd1;
                else if (cnt != 3'd0)  cnt <= cnt - 3'd1;
            end

            assign pre_busy[b] = (cnt != 3'd0);

            assert_pre_gap_R8: assert property (@(posedge clk) disable iff (rst)
                $rose(ras_i[b]) |-> !pre_busy[b]);
        end
    endgenerate

endmodule

// File: rtl/dxc_hit_decode.sv
module dxc_hit_decode import dxc_pkg::*; #(
    parameter int NB = 2,
    parameter int BW = 1
) (
    input  bank_cfg_t [NB-1:0] cfg,
    input  logic [AW-1:0]      addr,
    input  logic               ext,
    input  logic               hi_ok,
    input  logic [1:0]         acc,
    output logic               any_hit,
    output logic [BW-1:0]      pick,
    output logic               burst
);

    logic [AW-1:0] eff;
    logic [NB-1:0] hit;

    assign eff = ext_view(addr, ext, hi_ok);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_cmp
            assign hit[b] = (((eff ^ cfg[b].base) & ~cfg[b].mask) == '0)
                            && (ext || !cfg[b].deny[acc]);
        end
    endgenerate

    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (hit[b]) begin
                any_hit = 1'b1;
                pick    = BW'(b);
            end
        end
    end

    assign burst = ext || !cfg[pick].fast;

    always_comb begin
        if (any_hit) begin
            assert_lowest_R1: assert (hit[pick] &&
                ((hit & ((NB'(1) << pick) - NB'(1))) == '0));
        end
    end

endmodule

// File: rtl/dxc_seq.sv
module dxc_seq import dxc_pkg::*; #(
    parameter int NB   = 2,
    parameter int BW   = 1,
    parameter int MA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              any_hit,
    input  logic [BW-1:0]     hit_idx,
    input  logic              hit_burst,
    input  logic [MA_W-1:0]   row_in,
    input  logic [MA_W-3:0]   col_in,
    input  logic [NB-1:0]     pre_busy,
    output logic [NB-1:0]     pre_start,
    output logic              req_ready,
    output logic [NB-1:0]     ras_o,
    output logic              cas_o,
    output logic              ta_o,
    output logic              ta_oe,
    output logic              addr_oe,
    output logic [MA_W-1:0]   mux_addr,
    output logic              no_hit
);

    seq_state_e        st;
    logic [BW-1:0]     bank_q;
    logic [BW-1:0]     open_bank;
    logic              open_q;
    logic              burst_q;
    logic [1:0]        beat_q;
    logic [MA_W-1:0]   row_q;
    logic [MA_W-3:0]   col_q;
    logic              nohit_q;
    logic              take;
    logic              last_beat;

    assign take      = (st == ST_IDLE) && req_valid;
    assign last_beat = (st == ST_CSTB) && (beat_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bank_q    <= '0;
            open_bank <= '0;
            open_q    <= 1'b0;
            burst_q   <= 1'b1;
            beat_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
            nohit_q   <= 1'b0;
        end else begin
            nohit_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    if (any_hit) begin
                        bank_q  <= hit_idx;
                        burst_q <= hit_burst;
                        row_q   <= row_in;
                        col_q   <= col_in;
                        beat_q  <= '0;
                        open_q  <= 1'b0;
                        st      <= open_q ? ST_CLOSE : ST_WAIT;
                    end else begin
                        nohit_q <= 1'b1;
                    end
                end
                ST_CLOSE: st <= ST_WAIT;
                ST_WAIT:  if (!pre_busy[bank_q]) st <= ST_ROW;
                ST_ROW:   st <= ST_CSET;
                ST_CSET:  st <= ST_CSTB;
                ST_CSTB: begin
                    if (beat_q == 2'd3) begin
                        st <= ST_FIN;
                        if (!burst_q) begin
                            open_q    <= 1'b1;
                            open_bank <= bank_q;
                        end
                    end else begin
                        beat_q <= beat_q + 2'd1;
                        st     <= ST_CSET;
                    end
                end
                ST_FIN:   st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pre_start = '0;
        if (take && any_hit && open_q) pre_start[open_bank] = 1'b1;
        if (last_beat && burst_q)      pre_start[bank_q]    = 1'b1;
    end

    always_comb begin
        ras_o = '0;
        if (st == ST_ROW || st == ST_CSET || st == ST_CSTB)
            ras_o[bank_q] = 1'b1;
        if (open_q && (st == ST_IDLE || st == ST_FIN))
            ras_o[open_bank] = 1'b1;
    end

    assign req_ready = (st == ST_IDLE);
    assign cas_o     = (st == ST_CSTB);
    assign ta_o      = (st == ST_CSTB);
    assign addr_oe   = (st == ST_ROW) || (st == ST_CSET) || (st == ST_CSTB);
    assign ta_oe     = addr_oe || (st == ST_FIN);
    assign no_hit    = nohit_q;

    always_comb begin
        if (st == ST_ROW)                        mux_addr = row_q;
        else if (st == ST_CSET || st == ST_CSTB) mux_addr = {col_q, beat_q};
        else                                     mux_addr = '0;
    end

    assert_one_row_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ras_o));
    assert_ta_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ta_o |=> !ta_o);
    assert_ta_bus_R6: assert property (@(posedge clk) disable iff (rst)
        ta_o |-> (addr_oe && $countones(ras_o) == 1));
    assert_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe) |-> (!cas_o && !ta_o && ta_oe));
    assert_ta_release_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe) |=> !ta_oe);
    assert_burst_close_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(addr_oe) && burst_q) |-> (ras_o == '0));
    assert_fast_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(addr_oe) && !burst_q) |-> ($stable(ras_o) && ras_o != '0));
    assert_quiet_miss_R4: assert property (@(posedge clk) disable iff (rst)
        no_hit |-> (!cas_o && !ta_o && !addr_oe && req_ready));

endmodule

// File: rtl/dram_xm_ctrl.sv
module dram_xm_ctrl import dxc_pkg::*; #(
    parameter int NB      = 2,
    parameter int MA_W    = 10,
    parameter int ROW_LSB = 10,
    localparam int BW     = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [BW-1:0]     cfg_sel,
    input  logic [31:0]       cfg_base,
    input  logic [31:0]       cfg_mask,
    input  logic [3:0]        cfg_deny,
    input  logic              cfg_fast,
    input  logic [1:0]        cfg_pre,
    input  logic              hi_pins_ext,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic [1:0]        req_type,
    input  logic [31:0]       req_addr,
    output logic              req_ready,
    output logic [NB-1:0]     ras_o,
    output logic              cas_o,
    output logic              ta_o,
    output logic              ta_oe,
    output logic              addr_oe,
    output logic [MA_W-1:0]   mux_addr,
    output logic              no_hit
);

    bank_cfg_t            cfg_in;
    bank_cfg_t [NB-1:0]   cfg_q;
    logic [NB-1:0]        pre_busy;
    logic [NB-1:0]        pre_start;
    logic                 any_hit;
    logic [BW-1:0]        hit_idx;
    logic                 hit_burst;

    assign cfg_in = '{base: cfg_base, mask: cfg_mask, deny: cfg_deny,
                      fast: cfg_fast, pre: cfg_pre};

    dxc_bank_regs #(.NB(NB), .BW(BW)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_in(cfg_in), .pre_start(pre_start), .ras_i(ras_o),
        .cfg_q(cfg_q), .pre_busy(pre_busy)
    );

    dxc_hit_decode #(.NB(NB), .BW(BW)) u_hit (
        .cfg(cfg_q), .addr(req_addr), .ext(req_ext), .hi_ok(hi_pins_ext),
        .acc(req_type), .any_hit(any_hit), .pick(hit_idx), .burst(hit_burst)
    );

    dxc_seq #(.NB(NB), .BW(BW), .MA_W(MA_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .any_hit(any_hit),
        .hit_idx(hit_idx), .hit_burst(hit_burst),
        .row_in(req_addr[ROW_LSB +: MA_W]), .col_in(req_addr[MA_W-1:2]),
        .pre_busy(pre_busy), .pre_start(pre_start), .req_ready(req_ready),
        .ras_o(ras_o), .cas_o(cas_o), .ta_o(ta_o), .ta_oe(ta_oe),
        .addr_oe(addr_oe), .mux_addr(mux_addr), .no_hit(no_hit)
    );

endmodule

// File: tb/sim_dram_xm_ctrl.sv
module sim_dram_xm_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_mask = '0;
    logic [3:0]  cfg_deny = '0;
    logic        cfg_fast = 1'b0;
    logic [1:0]  cfg_pre = '0;
    logic        hi_pins_ext = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ext = 1'b0;
    logic [1:0]  req_type = '0;
    logic [31:0] req_addr = '0;
    logic        req_ready, cas_o, ta_o, ta_oe, addr_oe, no_hit;
    logic [1:0]  ras_o;
    logic [9:0]  mux_addr;

    always #4 clk = ~clk;

    dram_xm_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_deny(cfg_deny),
        .cfg_fast(cfg_fast), .cfg_pre(cfg_pre), .hi_pins_ext(hi_pins_ext),
        .req_valid(req_valid), .req_ext(req_ext), .req_type(req_type),
        .req_addr(req_addr), .req_ready(req_ready), .ras_o(ras_o),
        .cas_o(cas_o), .ta_o(ta_o), .ta_oe(ta_oe), .addr_oe(addr_oe),
        .mux_addr(mux_addr), .no_hit(no_hit)
    );

    typedef struct packed {
        logic       nohit;
        logic [1:0] ras;
        logic [9:0] col;
        logic [9:0] row;
        logic       last;
        logic [1:0] after;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor / scoreboard ----------------
    bit         prev_oe  = 1'b0;
    bit         pend_end = 1'b0;
    bit         pend_tri = 1'b0;
    logic [1:0] end_ras  = '0;
    bit         seen0    = 1'b0;
    int         run0     = 0;
    int         last_gap = 0;

    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (pend_tri) begin
                chk(ta_oe == 1'b0, "R7", "ta_oe after end", 32'(ta_oe), 0);
                pend_tri = 1'b0;
            end
            if (pend_end) begin
                chk({cas_o, ta_o, addr_oe} == 3'b000, "R7", "end strobes",
                    32'({cas_o, ta_o, addr_oe}), 0);
                chk(ta_oe == 1'b1, "R7", "ta_oe in end", 32'(ta_oe), 1);
                chk(ras_o == end_ras, "R8", "ras in end cycle",
                    32'(ras_o), 32'(end_ras));
                pend_end = 1'b0;
                pend_tri = 1'b1;
            end
            if (addr_oe && !prev_oe) begin
                if (sb.size() == 0)
                    chk(1'b0, "R5", "row cycle without request", 1, 0);
                else begin
                    chk(mux_addr == sb[0].row, "R5", "row address",
                        32'(mux_addr), 32'(sb[0].row));
                    chk(ras_o == sb[0].ras && !cas_o, "R5", "row strobe",
                        32'({cas_o, ras_o}), 32'(sb[0].ras));
                end
            end
            if (ta_o) begin
                if (sb.size() == 0)
                    chk(1'b0, "R6", "unexpected TA", 1, 0);
                else begin
                    e = sb.pop_front();
                    chk(!e.nohit, "R4", "TA where miss expected", 1, 0);
                    chk(cas_o == 1'b1, "R6", "CAS with TA", 32'(cas_o), 1);
                    chk(ras_o == e.ras, "R5", "ras during byte",
                        32'(ras_o), 32'(e.ras));
                    chk(mux_addr == e.col, "R5", "column address",
                        32'(mux_addr), 32'(e.col));
                    if (e.last) begin
                        pend_end = 1'b1;
                        end_ras  = e.after;
                    end
                end
            end
            if (no_hit) begin
                if (sb.size() == 0)
                    chk(1'b0, "R4", "unexpected miss", 1, 0);
                else begin
                    e = sb.pop_front();
                    chk(e.nohit, "R4", "miss where hit expected", 0, 1);
                    chk({cas_o, ta_o, addr_oe} == 3'b000, "R4", "quiet miss",
                        32'({cas_o, ta_o, addr_oe}), 0);
                end
            end
            prev_oe = addr_oe;
            if (ras_o[0]) begin
                if (seen0 && run0 > 0) last_gap = run0;
                run0  = 0;
                seen0 = 1'b1;
            end else if (seen0) begin
                run0++;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic set_bank(input int b, input logic [31:0] base,
                            input logic [31:0] mask, input logic [3:0] deny,
                            input logic fast, input logic [1:0] pre);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = b[0:0]; cfg_base = base; cfg_mask = mask;
        cfg_deny = deny; cfg_fast = fast; cfg_pre = pre;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic issue(input logic ext, input logic [1:0] typ,
                         input logic [31:0] addr, input int bank,
                         input logic [1:0] after);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (bank < 0) begin
            e = '0;
            e.nohit = 1'b1;
            sb.push_back(e);
        end else begin
            for (int k = 0; k < 4; k++) begin
                e.nohit = 1'b0;
                e.ras   = 2'(1 << bank);
                e.col   = {addr[9:2], 2'(k)};
                e.row   = addr[19:10];
                e.last  = (k == 3);
                e.after = after;
                sb.push_back(e);
            end
        end
        req_valid = 1'b1; req_ext = ext; req_type = typ; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic route(input string tag, input logic ext,
                         input logic [1:0] typ, input logic [31:0] addr,
                         input int bank, input logic [1:0] after);
        issue(ext, typ, addr, bank, after);
        chk(no_hit == (bank < 0), tag, "hit decision", 32'(no_hit),
            32'(bank < 0));
        if (bank >= 0) begin
            while (!addr_oe) @(negedge clk);
            chk(ras_o == 2'(1 << bank), tag, "selected bank", 32'(ras_o),
                32'(1 << bank));
        end
    endtask

    task automatic settle();
        @(negedge clk);
        while (!req_ready || sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(req_ready == 1'b1, "R4", "ready after reset", 32'(req_ready), 1);
        chk({ras_o, cas_o, ta_o, ta_oe, addr_oe, no_hit} == 7'd0, "R5",
            "pins after reset", 32'({ras_o, cas_o, ta_o, ta_oe, addr_oe, no_hit}), 0);

        set_bank(0, 32'h0000_0000, 32'h000F_FFFF, 4'h0, 1'b0, 2'd3);
        set_bank(1, 32'h0010_0000, 32'h000F_FFFF, 4'hF, 1'b1, 2'd0);

        // R5/R6 basic core burst on bank 0
        route("R1", 1'b0, 2'd1, 32'h0001_2344, 0, 2'b00);
        // R8 back-to-back on the same bank: precharge P=4 -> gap >= 5
        route("R8", 1'b0, 2'd0, 32'h0003_FC08, 0, 2'b00);
        settle();
        chk(last_gap >= 5, "R8", "RAS low cycles before reopen", last_gap, 5);

        // R4 miss: no bank covers this address
        issue(1'b0, 2'd1, 32'h0500_0000, -1, 2'b00);
        chk(no_hit == 1'b1 && req_ready == 1'b1, "R4", "miss flag and ready",
            32'({no_hit, req_ready}), 3);
        @(negedge clk);
        chk(no_hit == 1'b0, "R4", "miss flag one cycle", 32'(no_hit), 0);
        chk(ras_o == 2'b00, "R4", "no RAS on miss", 32'(ras_o), 0);

        // R2 top nibble ignored for the external master only
        route("R2", 1'b1, 2'd0, 32'hA001_0010, 0, 2'b00);
        route("R2", 1'b0, 2'd0, 32'hA001_0010, -1, 2'b00);
        hi_pins_ext = 1'b0;
        route("R2", 1'b1, 2'd0, 32'h0301_0020, 0, 2'b00);
        hi_pins_ext = 1'b1;
        route("R2", 1'b1, 2'd0, 32'h0301_0020, -1, 2'b00);
        settle();

        // R3 all refuse bits set on bank 1: core refused, external accepted
        route("R3", 1'b0, 2'd3, 32'h0010_0040, -1, 2'b00);
        // R9 external to a fast bank uses burst timing (RAS closes)
        route("R3", 1'b1, 2'd3, 32'h0010_0040, 1, 2'b00);
        settle();

        // R1 overlapping banks: lowest wins
        set_bank(1, 32'h0000_0000, 32'h000F_FFFF, 4'h0, 1'b1, 2'd0);
        route("R1", 1'b0, 2'd1, 32'h0000_0020, 0, 2'b00);
        settle();

        // R3 refuse bit 2 (supervisor code) on bank 0 only
        set_bank(0, 32'h0000_0000, 32'h000F_FFFF, 4'b0100, 1'b0, 2'd3);
        route("R3", 1'b0, 2'd2, 32'h0000_0010, 1, 2'b10);
        settle();
        for (int i = 0; i < 3; i++) begin
            chk(ras_o == 2'b10, "R9", "fast page held open", 32'(ras_o), 2);
            @(negedge clk);
        end
        // next request closes the open page first
        issue(1'b0, 2'd0, 32'h0000_0420, 0, 2'b00);
        chk(ras_o == 2'b00, "R9", "close cycle drops RAS", 32'(ras_o), 0);
        settle();
        chk(sb.size() == 0, "R5", "all expected bytes seen", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule